// File: doc/BRIEF.md
# Double-Column Pixel Configuration Shift Loader

This block sets the per-pixel configuration latches of a pixel array one double column at a time. The latches cannot be written directly. Each configuration bit is first shifted serially into a chain that holds one bit for every pixel of a double column. A load strobe then copies the chain into the latch planes chosen by a plane-enable mask, in the double column chosen by an address. Each pixel owns `N_PLANES` latch bits, one per plane. The last stage of the chain is also driven to a serial output, so shifting new data in pushes the old contents out for readback.

The full array uses 336 rows per column and 40 double columns. The default parameters are much smaller, 4 rows and 3 double columns, to keep the latch storage small at elaboration. The strobe comes from a command decoder that is not part of this block. If the strobe arrives while shifting is in progress, the copy is held back until the chain stops moving. The latched bits leave the block on a flat output bus that feeds the pixels.

Top module: `pcfg_dc_loader`

## Requirements
- R1: After reset, every latch bit on `latch_o` is 0 and `shift_dout_o` is 0.
- R2: In each cycle with `shift_en_i` high, one bit of `shift_din_i` enters the chain. `shift_dout_o` shows the bit that entered `CHAIN_LEN` shifts earlier, where `CHAIN_LEN` = 2*`ROWS`. While `shift_en_i` is low, `shift_dout_o` holds its value.
- R3: Chain position p maps to pixel p of the double column, where p = col*`ROWS` + row. The bit shifted in last lands in position 0. The latch for double column d, pixel p and plane k is bit ((d*`CHAIN_LEN` + p)*`N_PLANES` + k) of `latch_o`.
- R4: A copy writes the chain pattern into every plane whose bit is set in `plane_en_i`. Every plane whose bit is clear keeps its value.
- R5: A copy changes only the double column given by `dc_addr_i`. An address of `N_DC` or above changes no latch.
- R6: A strobe on `load_i` while `shift_en_i` is high is deferred. It takes effect at the first clock edge where `shift_en_i` is low. It uses the address and plane mask captured with the most recent strobe, and it stores the chain contents as they stand once shifting has stopped.
- R7: A copy leaves the chain unchanged, so the loaded pattern can still be shifted out afterwards.
- R8: A copy applied at a clock edge is visible on `latch_o` right after that edge. With no copy, `latch_o` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| shift_en_i | input | 1 | Shift the chain by one position |
| shift_din_i | input | 1 | Serial data into chain position 0 |
| shift_dout_o | output | 1 | Serial data out of the last chain position |
| load_i | input | 1 | Copy strobe |
| plane_en_i | input | N_PLANES | Latch planes that receive the copy |
| dc_addr_i | input | DC_W | Target double column |
| latch_o | output | N_DC*2*ROWS*N_PLANES | All per-pixel latch bits |

## Verification
The assertions check three properties on every cycle. The serial output and the chain stay still when nothing shifts. The latches stay still when no copy is applied. No write happens while shifting, and a deferred strobe fires as soon as shifting stops. The bench sweeps every double-column address, including the invalid one, and every single plane, plus several multi-plane masks. It compares the whole latch bus with an arithmetic model after each copy. Only the bench scenarios can show three further behaviours: the mapping of chain position to pixel, readback of loaded data through the serial output, and the rule that the latest strobe wins when several arrive during one shift burst.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
  function automatic int unsigned lat_idx(int unsigned dc, int unsigned pix,
                                          int unsigned plane, int unsigned pix_per_dc,
                                          int unsigned n_planes);
    return (dc * pix_per_dc + pix) * n_planes + plane;
  endfunction
endpackage

// File: rtl/pcfg_shift_chain.sv
module pcfg_shift_chain #(
  parameter int unsigned LEN = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           shift_en_i,
  input  logic           din_i,
  output logic [LEN-1:0] chain_o,
  output logic           dout_o
);
  logic [LEN-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sr_q <= '0;
    else if (shift_en_i) sr_q <= {sr_q[LEN-2:0], din_i};
  end

  assign chain_o = sr_q;
  assign dout_o  = sr_q[LEN-1];

  assert_dout_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_i |=> $stable(dout_o));
endmodule

// File: rtl/pcfg_load_seq.sv
module pcfg_load_seq #(
  parameter int unsigned N_PLANES = 13,
  parameter int unsigned DC_W     = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                shift_en_i,
  input  logic                load_i,
  input  logic [N_PLANES-1:0] plane_en_i,
  input  logic [DC_W-1:0]     dc_addr_i,
  output logic                wr_o,
  output logic [N_PLANES-1:0] wr_planes_o,
  output logic [DC_W-1:0]     wr_dc_o
);
  logic                pend_q;
  logic [N_PLANES-1:0] planes_q;
  logic [DC_W-1:0]     dc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      planes_q <= '0;
      dc_q     <= '0;
    end else begin
      pend_q <= (load_i || pend_q) && shift_en_i;
      if (load_i) begin
        planes_q <= plane_en_i;
        dc_q     <= dc_addr_i;
      end
    end
  end

  // a fresh strobe overrides any held request
  assign wr_o        = (load_i || pend_q) && !shift_en_i;
  assign wr_planes_o = load_i ? plane_en_i : planes_q;
  assign wr_dc_o     = load_i ? dc_addr_i  : dc_q;

  assert_deferred_fires_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(load_i && shift_en_i) && !shift_en_i |-> wr_o);
endmodule

// File: rtl/pcfg_latch_dc.sv
module pcfg_latch_dc #(
  parameter int unsigned PIX      = 8,
  parameter int unsigned N_PLANES = 13
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic [N_PLANES-1:0]     plane_en_i,
  input  logic [PIX-1:0]          data_i,
  output logic [PIX*N_PLANES-1:0] latch_o
);
  logic [PIX*N_PLANES-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= '0;
    else if (wr_i) begin
      for (int unsigned p = 0; p < PIX; p++)
        for (int unsigned k = 0; k < N_PLANES; k++)
          if (plane_en_i[k]) lat_q[p*N_PLANES+k] <= data_i[p];
    end
  end

  assign latch_o = lat_q;

  assert_latch_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(latch_o));
endmodule

// File: rtl/pcfg_dc_loader.sv
module pcfg_dc_loader #(
  parameter int unsigned ROWS     = 4,
  parameter int unsigned N_DC     = 3,
  parameter int unsigned N_PLANES = 13,
  localparam int unsigned CHAIN_LEN = 2 * ROWS,
  localparam int unsigned DC_W      = (N_DC > 1) ? $clog2(N_DC) : 1,
  localparam int unsigned DC_BITS   = CHAIN_LEN * N_PLANES,
  localparam int unsigned LAT_BITS  = N_DC * DC_BITS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                shift_en_i,
  input  logic                shift_din_i,
  output logic                shift_dout_o,
  input  logic                load_i,
  input  logic [N_PLANES-1:0] plane_en_i,
  input  logic [DC_W-1:0]     dc_addr_i,
  output logic [LAT_BITS-1:0] latch_o
);
  logic [CHAIN_LEN-1:0] chain_w;
  logic                 wr_w;
  logic [N_PLANES-1:0]  wr_planes_w;
  logic [DC_W-1:0]      wr_dc_w;
  logic [N_DC-1:0]      dc_hit_w;

  pcfg_shift_chain #(.LEN(CHAIN_LEN)) u_chain (
    .clk_i, .rst_ni, .shift_en_i, .din_i(shift_din_i),
    .chain_o(chain_w), .dout_o(shift_dout_o)
  );

  pcfg_load_seq #(.N_PLANES(N_PLANES), .DC_W(DC_W)) u_seq (
    .clk_i, .rst_ni, .shift_en_i, .load_i, .plane_en_i, .dc_addr_i,
    .wr_o(wr_w), .wr_planes_o(wr_planes_w), .wr_dc_o(wr_dc_w)
  );

  for (genvar d = 0; d < N_DC; d++) begin : g_dc
    assign dc_hit_w[d] = wr_w && (wr_dc_w == DC_W'(d));
    pcfg_latch_dc #(.PIX(CHAIN_LEN), .N_PLANES(N_PLANES)) u_lat (
      .clk_i, .rst_ni, .wr_i(dc_hit_w[d]), .plane_en_i(wr_planes_w),
      .data_i(chain_w), .latch_o(latch_o[d*DC_BITS +: DC_BITS])
    );
  end

  assert_one_dc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dc_hit_w));
  assert_no_write_while_shift_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |-> !wr_w);
  assert_copy_keeps_chain_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_w |=> $stable(chain_w));
endmodule

// File: tb/pcfg_dc_loader_tb_top.sv
module pcfg_dc_loader_tb_top;
  localparam int ROWS = 4, N_DC = 3, NP = 13;
  localparam int L = 2 * ROWS, DC_W = 2, LB = N_DC * L * NP;

  logic clk = 0, rst_n = 0;
  logic shift_en = 0, din = 0, load = 0;
  logic [NP-1:0] planes = '0;
  logic [DC_W-1:0] dc = '0;
  logic dout;
  logic [LB-1:0] lat, model;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pcfg_dc_loader #(.ROWS(ROWS), .N_DC(N_DC), .N_PLANES(NP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .shift_en_i(shift_en), .shift_din_i(din),
    .shift_dout_o(dout), .load_i(load), .plane_en_i(planes), .dc_addr_i(dc),
    .latch_o(lat)
  );

  task automatic check_lat(string req);
    total++;
    if (lat !== model) begin
      bad++;
      $display("FAIL %s latch actual=%h expected=%h", req, lat, model);
    end
  endtask

  task automatic check_bit(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s dout actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic void apply(int d, logic [NP-1:0] m, logic [L-1:0] pat);
    if (d < N_DC)
      for (int p = 0; p < L; p++)
        for (int k = 0; k < NP; k++)
          if (m[k]) model[(d*L + p)*NP + k] = pat[p];
  endfunction

  // pushes pat[L-1] first so chain position p ends up holding pat[p]
  task automatic push(logic [L-1:0] pat);
    for (int i = L - 1; i >= 0; i--) begin
      @(negedge clk); shift_en = 1; din = pat[i];
    end
    @(negedge clk); shift_en = 0; din = 0;
  endtask

  task automatic do_load(int d, logic [NP-1:0] m);
    load = 1; planes = m; dc = DC_W'(d);
    @(negedge clk); load = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [L-1:0] pa, pb;
    model = '0;
    repeat (3) @(negedge clk);
    check_lat("R1");
    check_bit("R1", dout, 1'b0);
    rst_n = 1;
    @(negedge clk);

    // R3 R4 R5: every address incl. out-of-range, every single plane
    for (int d = 0; d < 4; d++)
      for (int k = 0; k < NP; k++) begin
        pa = L'((d * 37 + k * 11 + 5) ^ (k << 3));
        push(pa);
        do_load(d, NP'(1) << k);
        apply(d, NP'(1) << k, pa);
        check_lat(d >= N_DC ? "R5" : "R3");
      end

    // R4 multi-plane masks
    push(8'hA5); do_load(1, 13'h1555); apply(1, 13'h1555, 8'hA5); check_lat("R4");
    push(8'h3C); do_load(0, 13'h0AAA); apply(0, 13'h0AAA, 8'h3C); check_lat("R4");
    push(8'hFF); do_load(2, 13'h1FFF); apply(2, 13'h1FFF, 8'hFF); check_lat("R4");
    push(8'h00); do_load(2, 13'h0000); check_lat("R4");

    // R2 hold while idle
    pa = 8'h96;
    push(pa);
    for (int i = 0; i < 4; i++) begin
      check_bit("R2", dout, pa[L-1]);
      @(negedge clk);
    end

    // R7 R2 readback after copy
    do_load(0, 13'h0010); apply(0, 13'h0010, pa); check_lat("R8");
    pb = 8'h5B;
    for (int i = L - 1; i >= 0; i--) begin
      check_bit("R7", dout, pa[i]);
      shift_en = 1; din = pb[i];
      @(negedge clk);
    end
    shift_en = 0; din = 0;

    // R6 strobe during shift is deferred
    pa = 8'hC3;
    for (int i = L - 1; i >= 0; i--) begin
      shift_en = 1; din = pa[i];
      load = (i == 4); planes = 13'h0020; dc = 2'd2;
      @(negedge clk);
      load = 0;
      check_lat("R6");
    end
    shift_en = 0; din = 0;
    check_lat("R6");
    @(negedge clk);
    apply(2, 13'h0020, pa);
    check_lat("R6");

    // R6 latest strobe wins
    pa = 8'h71;
    for (int i = L - 1; i >= 0; i--) begin
      shift_en = 1; din = pa[i];
      load = (i == 6 || i == 2);
      planes = (i == 6) ? 13'h0001 : 13'h0800;
      dc = (i == 6) ? 2'd0 : 2'd1;
      @(negedge clk);
      load = 0;
    end
    shift_en = 0; din = 0;
    @(negedge clk);
    apply(1, 13'h0800, pa);
    check_lat("R6");
    repeat (3) @(negedge clk);
    check_lat("R8");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule